// File: doc/BRIEF.md
# Two-Level Standby Power Controller

This block sequences a switchable core power domain between normal operation and two depths of standby. In the shallow depth (resume standby) the core supply is cut while the on-chip RAM keeps its contents in a low-voltage retention state; in the deep depth (ultra standby) the RAM supply is removed as well, trading its contents for lower leakage. The controller itself lives in an always-on domain and drives the core power switches, the isolation clamps on signals leaving the core, the RAM retention and RAM supply controls, and the core reset.

Software saves most of its state into RAM and then raises a standby request with the chosen depth. For the shallow depth the controller first copies a small set of registers needed at once after wake-up (the boot address and key control words) into always-on backup latches, then clamps, parks the RAM and opens the switches. A wake input brings the domain back in the reverse order; after a shallow standby the saved words are handed back to the core with a one-cycle valid pulse and the boot is flagged as warm, while a deep standby ends in a cold reset boot with no restore. A wake that arrives while entry is still running is remembered, so entry always runs to its end.

Top module: `stdby_power_ctrl`

## Requirements
- R1: After reset the outputs show the active state: switches on (`pwr_sw_on_o`=1), isolation off, retention off, RAM supply on, core reset released, no restore pulse, `warm_boot_o`=0 and `mode_o`=0.
- R2: A request with `stby_deep_i`=0 sampled in the active state captures `live_regs_i` on the next clock edge, raises isolation after the second edge, retention after the third, and opens the switches (and asserts core reset) after the fourth.
- R3: A request with `stby_deep_i`=1 captures nothing, raises isolation after the first edge, removes RAM supply (retention stays 0) after the second, and opens the switches after the third.
- R4: Whenever the switches are off, isolation is on and core reset is asserted; retention is only ever on while isolation is on.
- R5: In standby the controller stays put until a wake; a standby request seen outside the active state has no effect on any output.
- R6: A wake seen in standby closes the switches after the next edge; then RAM retention is released (or RAM supply restored), then the restore step (shallow only), then isolation is released, and core reset is released one cycle after isolation.
- R7: On exit from resume standby, `restore_valid_o` is high for exactly one cycle with `restore_data_o` equal to the words captured at entry, even if `live_regs_i` changed since; afterwards `warm_boot_o`=1.
- R8: On exit from ultra standby no restore pulse occurs and `warm_boot_o`=0.
- R9: A wake pulse seen during any entry step is remembered: standby is reached and the switches close again on the following cycle.
- R10: A wake pulse seen while active is ignored and does not shorten a later standby.
- R11: `mode_o` reads 0 for active, 1 for resume standby and 2 for ultra standby; it is nonzero from the cycle the switches open until core reset is released, and never 3.
- R12: After the switches close, the RAM stays parked for exactly `SETTLE_CYC` cycles before it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Always-on active-low reset |
| stby_req_i | input | 1 | Standby request from software, sampled in active state |
| stby_deep_i | input | 1 | Depth of the request: 0 resume, 1 ultra |
| wake_i | input | 1 | Wake event |
| live_regs_i | input | NUM_REGS*REG_W | Current values of the registers to back up |
| pwr_sw_on_o | output | 1 | Core power switch enable (1 = powered) |
| iso_en_o | output | 1 | Isolation clamp enable |
| ram_retain_o | output | 1 | RAM retention mode |
| ram_pwr_on_o | output | 1 | RAM supply enable |
| core_rst_n_o | output | 1 | Core reset, active low |
| restore_valid_o | output | 1 | One-cycle pulse: restore data valid |
| restore_data_o | output | NUM_REGS*REG_W | Contents of the backup latches |
| warm_boot_o | output | 1 | Last exit restored registers |
| mode_o | output | 2 | Current mode: 0 active, 1 resume, 2 ultra |

## Verification
The wake input and an entry step can land on the same clock edge, most sharply on the edge that moves the sequence from parking the RAM into standby, where a wake could be lost or could abort the sequence halfway. The bench drives one-cycle wake pulses timed to the save step of a shallow entry and to the final entry edge of a deep entry, and judges that the switches still open for one full cycle with isolation and RAM parking in place, then close on the next cycle. A wake pulse given while active, followed by a later entry that must wait in standby, checks that nothing stale is carried over.

// File: rtl/stdby_pkg.sv
package stdby_pkg;

    typedef enum logic [1:0] {
        MODE_ACTIVE = 2'd0,
        MODE_RESUME = 2'd1,
        MODE_ULTRA  = 2'd2
    } pmode_e;

    typedef enum logic [3:0] {
        ST_ACTIVE,
        ST_SAVE,
        ST_ISO_ON,
        ST_RAM_CFG,
        ST_SLEEP,
        ST_PWR_ON,
        ST_RAM_REL,
        ST_RESTORE,
        ST_ISO_OFF
    } seq_state_e;

    typedef struct packed {
        logic sw_on;
        logic iso;
        logic ram_ret;
        logic ram_pwr;
        logic core_rst_n;
    } rail_ctrl_t;

    localparam rail_ctrl_t RAIL_ACTIVE = '{sw_on: 1'b1, iso: 1'b0, ram_ret: 1'b0,
                                          ram_pwr: 1'b1, core_rst_n: 1'b1};

    // Control levels that belong to each step; deep selects how the RAM is parked.
    function automatic rail_ctrl_t rail_for(input seq_state_e st, input logic deep);
        rail_ctrl_t r;
        r = RAIL_ACTIVE;
        case (st)
            ST_ACTIVE, ST_SAVE: r = RAIL_ACTIVE;
            ST_ISO_ON: r.iso = 1'b1;
            ST_RAM_CFG: begin
                r.iso     = 1'b1;
                r.ram_ret = ~deep;
                r.ram_pwr = ~deep;
            end
            ST_SLEEP: begin
                r.sw_on      = 1'b0;
                r.iso        = 1'b1;
                r.ram_ret    = ~deep;
                r.ram_pwr    = ~deep;
                r.core_rst_n = 1'b0;
            end
            ST_PWR_ON: begin
                r.iso        = 1'b1;
                r.ram_ret    = ~deep;
                r.ram_pwr    = ~deep;
                r.core_rst_n = 1'b0;
            end
            ST_RAM_REL, ST_RESTORE: begin
                r.iso        = 1'b1;
                r.core_rst_n = 1'b0;
            end
            ST_ISO_OFF: r.core_rst_n = 1'b0;
            default: r = RAIL_ACTIVE;
        endcase
        return r;
    endfunction

    function automatic pmode_e mode_for(input seq_state_e st, input logic deep);
        pmode_e m;
        case (st)
            ST_SLEEP, ST_PWR_ON, ST_RAM_REL, ST_RESTORE, ST_ISO_OFF:
                m = deep ? MODE_ULTRA : MODE_RESUME;
            default: m = MODE_ACTIVE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/stdby_settle_timer.sv
module stdby_settle_timer #(
    parameter int SETTLE_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done_o = run_i && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (!run_i || done_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R12
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0); // R12

endmodule

// File: rtl/stdby_backup_bank.sv
module stdby_backup_bank #(
    parameter int NUM_REGS = 3,
    parameter int REG_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      capture_i,
    input  logic [NUM_REGS*REG_W-1:0] live_i,
    output logic [NUM_REGS*REG_W-1:0] held_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        logic [REG_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (capture_i) slot_d = live_i[g*REG_W +: REG_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign held_o[g*REG_W +: REG_W] = slot_q;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(held_o)); // R7

endmodule

// File: rtl/stdby_seq_fsm.sv
module stdby_seq_fsm
    import stdby_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       deep_i,
    input  logic       wake_i,
    input  logic       settle_done_i,
    output logic       capture_o,
    output logic       timer_run_o,
    output rail_ctrl_t rail_o,
    output logic       restore_o,
    output logic       warm_o,
    output pmode_e     mode_o
);
    typedef struct packed {
        seq_state_e st;
        logic       deep;
        logic       wake_pend;
        logic       warm;
        rail_ctrl_t rail;
        logic       restore;
        pmode_e     mode;
    } fsm_t;

    localparam fsm_t FSM_RST = '{st: ST_ACTIVE, deep: 1'b0, wake_pend: 1'b0, warm: 1'b0,
                                 rail: RAIL_ACTIVE, restore: 1'b0, mode: MODE_ACTIVE};

    fsm_t d, q;

    always_comb begin
        d = q;
        case (q.st)
            ST_ACTIVE: begin
                if (req_i) begin
                    d.deep      = deep_i;
                    d.wake_pend = 1'b0;
                    d.warm      = 1'b0;
                    d.st        = deep_i ? ST_ISO_ON : ST_SAVE;
                end
            end
            ST_SAVE: begin
                d.wake_pend = q.wake_pend | wake_i;
                d.st        = ST_ISO_ON;
            end
            ST_ISO_ON: begin
                d.wake_pend = q.wake_pend | wake_i;
                d.st        = ST_RAM_CFG;
            end
            ST_RAM_CFG: begin
                d.wake_pend = q.wake_pend | wake_i;
                d.st        = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_i || q.wake_pend) begin
                    d.wake_pend = 1'b0;
                    d.st        = ST_PWR_ON;
                end
            end
            ST_PWR_ON: begin
                if (settle_done_i) d.st = ST_RAM_REL;
            end
            ST_RAM_REL: d.st = q.deep ? ST_ISO_OFF : ST_RESTORE;
            ST_RESTORE: begin
                d.warm = 1'b1;
                d.st   = ST_ISO_OFF;
            end
            ST_ISO_OFF: d.st = ST_ACTIVE;
            default:    d.st = ST_ACTIVE;
        endcase
        d.rail    = rail_for(d.st, d.deep);
        d.restore = (d.st == ST_RESTORE);
        d.mode    = mode_for(d.st, d.deep);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FSM_RST;
        else        q <= d;
    end

    assign capture_o   = (q.st == ST_SAVE);
    assign timer_run_o = (q.st == ST_PWR_ON);
    assign rail_o      = q.rail;
    assign restore_o   = q.restore;
    assign warm_o      = q.warm;
    assign mode_o      = q.mode;

    AST_ISO_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_o.sw_on |-> rail_o.iso); // R4
    AST_RST_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_o.sw_on |-> !rail_o.core_rst_n); // R4
    AST_RET_UNDER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
        rail_o.ram_ret |-> rail_o.iso); // R4
    AST_PARK_BEFORE_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail_o.sw_on) |-> $past(rail_o.iso) && $past(rail_o.ram_ret || !rail_o.ram_pwr)); // R2
    AST_RST_AFTER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_o.core_rst_n) |-> $past(!rail_o.iso) && !rail_o.iso); // R6
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3); // R11
    AST_RESTORE_SHALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        restore_o |-> mode_o == MODE_RESUME); // R7
    AST_RESTORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        restore_o |=> !restore_o); // R7
    AST_CAPTURE_SHALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |-> rail_o.sw_on && !rail_o.iso); // R2

endmodule

// File: rtl/stdby_power_ctrl.sv
module stdby_power_ctrl
    import stdby_pkg::*;
#(
    parameter int NUM_REGS   = 3,
    parameter int REG_W      = 32,
    parameter int SETTLE_CYC = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      stby_req_i,
    input  logic                      stby_deep_i,
    input  logic                      wake_i,
    input  logic [NUM_REGS*REG_W-1:0] live_regs_i,
    output logic                      pwr_sw_on_o,
    output logic                      iso_en_o,
    output logic                      ram_retain_o,
    output logic                      ram_pwr_on_o,
    output logic                      core_rst_n_o,
    output logic                      restore_valid_o,
    output logic [NUM_REGS*REG_W-1:0] restore_data_o,
    output logic                      warm_boot_o,
    output logic [1:0]                mode_o
);
    logic       capture;
    logic       timer_run;
    logic       settle_done;
    rail_ctrl_t rail;
    pmode_e     mode;

    stdby_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (stby_req_i),
        .deep_i        (stby_deep_i),
        .wake_i        (wake_i),
        .settle_done_i (settle_done),
        .capture_o     (capture),
        .timer_run_o   (timer_run),
        .rail_o        (rail),
        .restore_o     (restore_valid_o),
        .warm_o        (warm_boot_o),
        .mode_o        (mode)
    );

    stdby_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (timer_run),
        .done_o (settle_done)
    );

    stdby_backup_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .live_i    (live_regs_i),
        .held_o    (restore_data_o)
    );

    assign pwr_sw_on_o  = rail.sw_on;
    assign iso_en_o     = rail.iso;
    assign ram_retain_o = rail.ram_ret;
    assign ram_pwr_on_o = rail.ram_pwr;
    assign core_rst_n_o = rail.core_rst_n;
    assign mode_o       = mode;

    AST_MODE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_sw_on_o |-> mode_o != 2'd0); // R11
    AST_ULTRA_NO_RET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'd2 |-> !ram_retain_o); // R3

endmodule

// File: tb/stdby_power_ctrl_tb_top.sv
module stdby_power_ctrl_tb_top;
    localparam int NR = 3;
    localparam int RW = 32;
    localparam int S  = 5;
    localparam int BW = NR * RW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, deep = 1'b0, wake = 1'b0;
    logic [BW-1:0] live = '0;
    logic          sw_on, iso, ret, rampwr, crst_n, rvalid, warm;
    logic [BW-1:0] rdata;
    logic [1:0]    mode;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    stdby_power_ctrl #(.NUM_REGS(NR), .REG_W(RW), .SETTLE_CYC(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .stby_req_i(req), .stby_deep_i(deep), .wake_i(wake),
        .live_regs_i(live), .pwr_sw_on_o(sw_on), .iso_en_o(iso), .ram_retain_o(ret),
        .ram_pwr_on_o(rampwr), .core_rst_n_o(crst_n), .restore_valid_o(rvalid),
        .restore_data_o(rdata), .warm_boot_o(warm), .mode_o(mode)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    // rail vector: {sw_on, iso, ret, rampwr, crst_n}
    function automatic logic [4:0] rails();
        return {sw_on, iso, ret, rampwr, crst_n};
    endfunction

    task automatic wait_active();
        for (int i = 0; i < 60; i++) begin
            if (mode == 2'd0 && crst_n) break;
            nxt();
        end
    endtask

    task automatic t_reset();
        chk("R1 rails", rails(), 5'b10011);
        chk("R1 mode", mode, 2'd0);
        chk("R1 restore", rvalid, 1'b0);
        chk("R1 warm", warm, 1'b0);
    endtask

    task automatic t_resume(input logic [BW-1:0] a, input logic [BW-1:0] b);
        live = a; req = 1'b1; deep = 1'b0;
        nxt(); req = 1'b0;
        chk("R2 save step rails", rails(), 5'b10011);
        nxt(); live = b;
        chk("R2 iso step", rails(), 5'b11011);
        nxt();
        chk("R2 ret step", rails(), 5'b11111);
        chk("R11 entry mode", mode, 2'd0);
        nxt();
        chk("R2 off", rails(), 5'b01110);
        chk("R11 resume", mode, 2'd1);
        chk("R4 off iso/rst", {iso, crst_n}, 2'b10);
        // R5: stays, request during standby ignored
        req = 1'b1; deep = 1'b1;
        nxt(); nxt(); nxt();
        req = 1'b0; deep = 1'b0;
        chk("R5 stays", rails(), 5'b01110);
        chk("R5 mode", mode, 2'd1);
        wake = 1'b1;
        nxt(); wake = 1'b0;
        chk("R6 switch on", rails(), 5'b11110);
        for (int i = 2; i <= S; i++) nxt();
        chk("R12 parked at S", ret, 1'b1);
        nxt();
        chk("R12 ret released", rails(), 5'b11010);
        chk("R7 no pulse yet", rvalid, 1'b0);
        nxt();
        chk("R7 pulse", rvalid, 1'b1);
        chk("R7 data", rdata, a);
        chk("R6 iso held in restore", iso, 1'b1);
        nxt();
        chk("R6 iso off", rails(), 5'b10010);
        chk("R7 pulse one", rvalid, 1'b0);
        nxt();
        chk("R6 reset off", rails(), 5'b10011);
        chk("R11 back", mode, 2'd0);
        chk("R7 warm", warm, 1'b1);
    endtask

    task automatic t_ultra();
        live = {BW{1'b1}}; req = 1'b1; deep = 1'b1;
        nxt(); req = 1'b0; deep = 1'b0;
        chk("R3 iso first", rails(), 5'b11011);
        nxt();
        chk("R3 ram off", rails(), 5'b11001);
        nxt();
        chk("R3 off", rails(), 5'b01000);
        chk("R11 ultra", mode, 2'd2);
        chk("R8 warm cleared", warm, 1'b0);
        nxt(); nxt();
        wake = 1'b1;
        nxt(); wake = 1'b0;
        chk("R6 ultra switch on", rails(), 5'b11000);
        for (int i = 2; i <= S; i++) nxt();
        chk("R12 ultra ram still off", rampwr, 1'b0);
        nxt();
        chk("R6 ultra ram on", rails(), 5'b11010);
        chk("R8 no pulse a", rvalid, 1'b0);
        nxt();
        chk("R6 ultra iso off", rails(), 5'b10010);
        chk("R8 no pulse b", rvalid, 1'b0);
        nxt();
        chk("R8 cold boot", {rails(), warm}, 6'b100110);
        chk("R11 ultra back", mode, 2'd0);
    endtask

    task automatic t_wake_in_save();
        live = '0; req = 1'b1; deep = 1'b0;
        nxt(); req = 1'b0; wake = 1'b1;
        nxt(); wake = 1'b0;
        nxt();
        nxt();
        chk("R9 sleep reached", rails(), 5'b01110);
        nxt();
        chk("R9 wakes next", rails(), 5'b11110);
        wait_active();
    endtask

    task automatic t_wake_last_edge();
        req = 1'b1; deep = 1'b1;
        nxt(); req = 1'b0; deep = 1'b0;
        nxt(); wake = 1'b1;
        nxt(); wake = 1'b0;
        chk("R9 sleep on last edge", rails(), 5'b01000);
        chk("R9 mode", mode, 2'd2);
        nxt();
        chk("R9 switches back", rails(), 5'b11000);
        wait_active();
    endtask

    task automatic t_wake_active();
        wake = 1'b1;
        nxt(); wake = 1'b0;
        chk("R10 active unaffected", rails(), 5'b10011);
        req = 1'b1; deep = 1'b0;
        nxt(); req = 1'b0;
        for (int i = 0; i < 7; i++) nxt();
        chk("R10 still in standby", rails(), 5'b01110);
        wake = 1'b1;
        nxt(); wake = 1'b0;
        wait_active();
        chk("R10 returned", mode, 2'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        nxt(); nxt();
        rst_n = 1'b1;
        nxt();
        t_reset();
        t_resume({32'h1234_5678, 32'hcafe_0001, 32'h0bad_f00d},
                 {32'h1111_1111, 32'h2222_2222, 32'h3333_3333});
        t_ultra();
        t_wake_in_save();
        t_wake_last_edge();
        t_wake_active();
        t_resume({32'h0000_00a5, 32'h5a5a_0000, 32'h8000_0001}, '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule